// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port. It also derives the hot-plug interrupt from them. Software writes the control register with byte enables and reads both registers through a simple register port. The surrounding port logic reports a device being attached, an attention-button push and whether an electromechanical interlock is fitted. The block answers with a legacy interrupt level, a one-cycle message-interrupt request, a one-cycle request to detach the downstream devices, and the presence and link-active state.

Every control write counts as one command that completes in the cycle it is taken, so it always raises the command-completed event. Event status bits are write-one-to-clear. A status write that would clear an event software has not yet seen is rolled back as a whole, so that no event is lost. The notification level is recomputed every cycle from the next register state. A message request is issued only when that level rises, so repeating an event that is already pending produces nothing.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the control register reads 0x00C0 (attention indicator off, power indicator 00, power controller 0, all enables 0), the status register reads 0x0000, and irq_level_o, irq_msg_o, detach_o, present_o and link_up_o are all 0.
- R2: A control write (wr_sel_i=0) updates only the writable bits in enabled byte lanes (lane 0 = bits 7:0, lane 1 = bits 15:8). The writable bits are: button enable 0, presence-change enable 3, command-completed enable 4, interrupt enable 5, attention indicator 7:6, power indicator 9:8 and power controller 10. All other bits read 0, and bit 11 (interlock command) always reads 0.
- R3: A control write with at least one byte enable set raises the command-completed event, status bit 4, as the register updates.
- R4: A status write (wr_sel_i=1) with byte lane 0 enabled clears each event bit 4:0 written as 1. With lane 0 disabled, the write has no effect.
- R5: If a status write has a 1 in any event bit 4:0 that was 0 before the write, all five event bits keep their previous values.
- R6: A control write with bit 11 = 1 in lane 1 toggles the interlock status, status bit 7, when lock_present_i is 1. When lock_present_i is 0 it is ignored.
- R7: An attach pulse sets presence (status bit 6) and link_up_o. With run_i=1 it also sets presence-changed (bit 3) and button (bit 0). With run_i=0 it raises no event.
- R8: An attach pulse while the interlock status is 1 is refused and changes nothing.
- R9: A button pulse sets status bit 0.
- R10: The notification level is interrupt enable (control bit 5) AND at least one of: status bit 0 with control bit 0, status bit 3 with control bit 3, status bit 4 with control bit 4.
- R11: With msg_mode_i=0, irq_level_o follows the notification level one clock after the cause. With msg_mode_i=1, irq_level_o is 0 and irq_msg_o pulses for one cycle only when the level rises. An event that is already pending gives no pulse.
- R12: A control write that makes power controller = 1 with power indicator = 11, while presence is 1 and that condition was not already true, pulses detach_o for one cycle. It also clears presence and link-active and sets status bit 3. Writing the condition again, or a blink (10) indicator, gives no detach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | System running; before it is set, attach raises no event |
| msg_mode_i | input | 1 | 1 = message interrupts, 0 = legacy level interrupt |
| lock_present_i | input | 1 | Electromechanical interlock fitted |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 status |
| wr_be_i | input | 2 | Byte enables |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 1 | Read select: 0 control, 1 status |
| rd_data_o | output | 16 | Read data (combinational) |
| attach_i | input | 1 | Device attached pulse |
| button_i | input | 1 | Attention button pushed pulse |
| irq_level_o | output | 1 | Legacy interrupt level |
| irq_msg_o | output | 1 | One-cycle message interrupt request |
| detach_o | output | 1 | One-cycle request to detach downstream devices |
| present_o | output | 1 | Presence detect state |
| link_up_o | output | 1 | Data link layer active |

## Verification
The interrupt function is swept over all 16 combinations of the three event enables and the interrupt enable, each crossed with all 8 patterns of pending button, presence-change and command-completed events. This separates every term of the level equation and shows that each event gates only through its own enable. Message mode is tried with a first event, the same event repeated, a clear and a new event; this tells a rising-edge pulse from a level or a per-event pulse. Status writes that clear seen events, clear through a disabled lane, and clear an unseen event tell the plain write-one-to-clear path from the rollback. The detach is tried on entry into the off condition, on a rewrite of the same condition, and with a blinking indicator, which separates an edge test from a level test.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W = 16;
  localparam int LANES = REG_W / 8;
  localparam int EVT_W = 5;

  // control register field positions
  localparam int C_BTN_EN  = 0;
  localparam int C_PDC_EN  = 3;
  localparam int C_CC_EN   = 4;
  localparam int C_HPIE    = 5;
  localparam int C_ATTN_LO = 6;
  localparam int C_PWR_LO  = 8;
  localparam int C_PCTL    = 10;
  localparam int C_LOCKCMD = 11;

  // status register field positions
  localparam int S_BTN   = 0;
  localparam int S_PDC   = 3;
  localparam int S_CC    = 4;
  localparam int S_PRES  = 6;
  localparam int S_LOCK  = 7;

  localparam logic [1:0] IND_OFF = 2'b11;
  localparam logic [REG_W-1:0] CTL_WMASK = 16'h07F9;
  localparam logic [REG_W-1:0] CTL_RST   = 16'h00C0;
  localparam logic [EVT_W-1:0] EVT_SUP   = 5'b11001;

  function automatic logic [REG_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = be[i/8];
    return m;
  endfunction
endpackage

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [REG_W-1:0] data_i,
  input  logic             present_i,
  output logic [REG_W-1:0] ctl_q_o,
  output logic [EVT_W-1:0] evt_en_d_o,
  output logic             hpie_d_o,
  output logic             cmd_o,
  output logic             lock_cmd_o,
  output logic             detach_now_o,
  output logic             detach_q_o
);
  logic [REG_W-1:0] ctl_q, ctl_d, wmask;
  logic             off_old, off_new, det_q;

  always_comb begin
    wmask      = lane_mask(be_i) & CTL_WMASK;
    cmd_o      = wr_i & (|be_i);
    ctl_d      = cmd_o ? ((ctl_q & ~wmask) | (data_i & wmask)) : ctl_q;
    lock_cmd_o = cmd_o & be_i[C_LOCKCMD/8] & data_i[C_LOCKCMD];
    off_old    = ctl_q[C_PCTL] & (ctl_q[C_PWR_LO +: 2] == IND_OFF);
    off_new    = ctl_d[C_PCTL] & (ctl_d[C_PWR_LO +: 2] == IND_OFF);
    detach_now_o = cmd_o & present_i & off_new & ~off_old;
    evt_en_d_o = '0;
    evt_en_d_o[S_BTN] = ctl_d[C_BTN_EN];
    evt_en_d_o[S_PDC] = ctl_d[C_PDC_EN];
    evt_en_d_o[S_CC]  = ctl_d[C_CC_EN];
    hpie_d_o   = ctl_d[C_HPIE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      det_q <= 1'b0;
    end else begin
      if (cmd_o) ctl_q <= ctl_d;
      det_q <= detach_now_o;
    end
  end

  assign ctl_q_o    = ctl_q;
  assign detach_q_o = det_q;

  p_detach_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |=> !det_q);
endmodule

// File: rtl/hp_status_reg.sv
module hp_status_reg
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sta_wr_i,
  input  logic             lane0_i,
  input  logic [EVT_W-1:0] wdata_i,
  input  logic             lock_cmd_i,
  input  logic             lock_present_i,
  input  logic             detach_i,
  input  logic             cmd_i,
  input  logic             attach_i,
  input  logic             button_i,
  input  logic             run_i,
  output logic [EVT_W-1:0] evt_q_o,
  output logic [EVT_W-1:0] evt_d_o,
  output logic             present_o,
  output logic             link_o,
  output logic             lock_o
);
  logic [EVT_W-1:0] evt_q, evt_d, clr;
  logic             pres_q, pres_d, link_q, link_d, lock_q, lock_d;
  logic             stray, attach_ok, en;

  always_comb begin
    clr       = (sta_wr_i & lane0_i) ? wdata_i : '0;
    stray     = |(clr & ~evt_q);
    evt_d     = stray ? evt_q : (evt_q & ~clr);
    lock_d    = lock_q ^ (lock_cmd_i & lock_present_i);
    pres_d    = pres_q & ~detach_i;
    link_d    = link_q & ~detach_i;
    if (detach_i) evt_d[S_PDC] = 1'b1;
    if (cmd_i)    evt_d[S_CC]  = 1'b1;
    attach_ok = attach_i & ~lock_q;
    if (attach_ok) begin
      pres_d = 1'b1;
      link_d = 1'b1;
      if (run_i) begin
        evt_d[S_PDC] = 1'b1;
        evt_d[S_BTN] = 1'b1;
      end
    end
    if (button_i) evt_d[S_BTN] = 1'b1;
    en = sta_wr_i | cmd_i | attach_i | button_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      pres_q <= 1'b0;
      link_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (en) begin
      evt_q  <= evt_d;
      pres_q <= pres_d;
      link_q <= link_d;
      lock_q <= lock_d;
    end
  end

  assign evt_q_o   = evt_q;
  assign evt_d_o   = evt_d;
  assign present_o = pres_q;
  assign link_o    = link_q;
  assign lock_o    = lock_q;

  p_cc_on_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i |=> evt_q[S_CC]);
  p_no_spont_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sta_wr_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
  p_lock_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cmd_i && lock_present_i) |=> (lock_q != $past(lock_q)));
  p_detach_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (detach_i && !attach_i) |=> (!pres_q && !link_q && evt_q[S_PDC]));
endmodule

// File: rtl/hp_irq_gen.sv
module hp_irq_gen
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_mode_i,
  input  logic             hpie_d_i,
  input  logic [EVT_W-1:0] evt_en_d_i,
  input  logic [EVT_W-1:0] evt_d_i,
  output logic             irq_line_o,
  output logic             irq_msg_o
);
  logic level_q, level_d, line_q, line_d, msg_q, msg_d;

  always_comb begin
    level_d = hpie_d_i & (|(evt_d_i & evt_en_d_i & EVT_SUP));
    line_d  = ~msg_mode_i & level_d;
    msg_d   = msg_mode_i & level_d & ~level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      line_q  <= 1'b0;
      msg_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      line_q  <= line_d;
      msg_q   <= msg_d;
    end
  end

  assign irq_line_o = line_q;
  assign irq_msg_o  = msg_q;

  p_msg_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_q |-> (level_q && !$past(level_q)));
  p_line_quiet_msg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msg_mode_i) |-> !line_q);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             msg_mode_i,
  input  logic             lock_present_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [LANES-1:0] wr_be_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_sel_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             attach_i,
  input  logic             button_i,
  output logic             irq_level_o,
  output logic             irq_msg_o,
  output logic             detach_o,
  output logic             present_o,
  output logic             link_up_o
);
  logic [REG_W-1:0] ctl_q;
  logic [EVT_W-1:0] evt_en_d, evt_q, evt_d;
  logic             hpie_d, cmd, lock_cmd, detach_now, pres, link, lock;

  hp_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en_i & ~wr_sel_i), .be_i(wr_be_i),
    .data_i(wr_data_i), .present_i(pres), .ctl_q_o(ctl_q),
    .evt_en_d_o(evt_en_d), .hpie_d_o(hpie_d), .cmd_o(cmd),
    .lock_cmd_o(lock_cmd), .detach_now_o(detach_now), .detach_q_o(detach_o)
  );

  hp_status_reg u_sta (
    .clk(clk), .rst_n(rst_n), .sta_wr_i(wr_en_i & wr_sel_i),
    .lane0_i(wr_be_i[0]), .wdata_i(wr_data_i[EVT_W-1:0]),
    .lock_cmd_i(lock_cmd), .lock_present_i(lock_present_i),
    .detach_i(detach_now), .cmd_i(cmd), .attach_i(attach_i),
    .button_i(button_i), .run_i(run_i), .evt_q_o(evt_q), .evt_d_o(evt_d),
    .present_o(pres), .link_o(link), .lock_o(lock)
  );

  hp_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .msg_mode_i(msg_mode_i), .hpie_d_i(hpie_d),
    .evt_en_d_i(evt_en_d), .evt_d_i(evt_d), .irq_line_o(irq_level_o),
    .irq_msg_o(irq_msg_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i) begin
      rd_data_o[EVT_W-1:0] = evt_q;
      rd_data_o[S_PRES]    = pres;
      rd_data_o[S_LOCK]    = lock;
    end else begin
      rd_data_o = ctl_q;
      rd_data_o[C_LOCKCMD] = 1'b0;
    end
  end

  assign present_o = pres;
  assign link_up_o = link;
endmodule

// File: tb/hp_slot_ctrl_tb_top.sv
`timescale 1ns/1ps
module hp_slot_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, msg_mode = 1'b0, lock_present = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [1:0] wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0, rd_data;
  logic attach = 1'b0, button = 1'b0;
  logic irq_level, irq_msg, detach, present, link_up;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hp_slot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run), .msg_mode_i(msg_mode),
    .lock_present_i(lock_present), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_be_i(wr_be), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .attach_i(attach), .button_i(button),
    .irq_level_o(irq_level), .irq_msg_o(irq_msg), .detach_o(detach),
    .present_o(present), .link_up_o(link_up)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_be = be;
    @(negedge clk); wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic do_attach;
    @(negedge clk); attach = 1'b1; @(negedge clk); attach = 1'b0;
  endtask

  task automatic do_button;
    @(negedge clk); button = 1'b1; @(negedge clk); button = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    rd_sel = sel; #0.5; v = rd_data;
  endtask

  task automatic clear_events;
    logic [15:0] s;
    rd(1'b1, s);
    wr(1'b1, s & 16'h001F, 2'b01);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, v); chk("R1 ctl", v, 16'h00C0);
    rd(1'b1, v); chk("R1 sta", v, 16'h0000);
    chk("R1 outs", {irq_level, irq_msg, detach, present, link_up}, 0);

    // R7 attach before run: no events
    do_attach;
    rd(1'b1, v); chk("R7 pre-run sta", v, 16'h0040);
    chk("R7 pre-run link", link_up, 1);
    run = 1'b1;

    // R2 byte lanes, R3 command completed, R6 ignored without interlock
    wr(1'b0, 16'hFFFF, 2'b01);
    rd(1'b0, v); chk("R2 lane0", v, 16'h00F9);
    rd(1'b1, v); chk("R3 cc set", v[4], 1);
    wr(1'b0, 16'hFBFF, 2'b10);
    rd(1'b0, v); chk("R2 lane1 bit11 reads 0", v, 16'h03F9);
    rd(1'b1, v); chk("R6 no interlock fitted", v[7], 0);
    wr(1'b0, 16'h00C0, 2'b11);
    chk("R12 no detach with blink", detach, 0);

    // R10/R11 legacy sweep
    for (int e = 0; e < 16; e++) begin
      for (int p = 0; p < 8; p++) begin
        logic [15:0] cv;
        logic [4:0] ev;
        logic lvl;
        cv = 16'h00C0 | (e[0] ? 16'h1 : 16'h0) | (e[1] ? 16'h8 : 16'h0)
                      | (e[2] ? 16'h10 : 16'h0) | (e[3] ? 16'h20 : 16'h0);
        wr(1'b0, cv, 2'b11);
        clear_events;
        if (p[0]) do_button;
        if (p[1]) do_attach;
        if (p[2]) wr(1'b0, cv, 2'b11);
        ev  = {p[2], p[1], 2'b00, p[0] | p[1]};
        lvl = e[3] & ((ev[0] & e[0]) | (ev[3] & e[1]) | (ev[4] & e[2]));
        rd(1'b1, v);
        chk("R9 R7 R3 events", v[4:0], ev);
        chk("R10 R11 legacy level", irq_level, lvl);
        chk("R11 no msg in legacy", irq_msg, 0);
      end
    end

    // R4/R5 clear and rollback
    wr(1'b0, 16'h00C0, 2'b11);
    clear_events;
    do_button;
    rd(1'b1, v); chk("R9 button", v[4:0], 5'h01);
    wr(1'b0, 16'h00C0, 2'b11);
    wr(1'b1, 16'h001F, 2'b01);
    rd(1'b1, v); chk("R5 rollback", v[4:0], 5'h11);
    wr(1'b1, 16'h0011, 2'b00);
    rd(1'b1, v); chk("R4 lane disabled", v[4:0], 5'h11);
    wr(1'b1, 16'h0001, 2'b01);
    rd(1'b1, v); chk("R4 w1c button", v[4:0], 5'h10);
    wr(1'b1, 16'h0010, 2'b01);
    rd(1'b1, v); chk("R4 w1c cc", v[4:0], 5'h00);

    // R11 message mode
    msg_mode = 1'b1;
    wr(1'b0, 16'h00E1, 2'b11);
    chk("R11 no msg cc unenabled", irq_msg, 0);
    do_button;
    chk("R11 msg pulse", irq_msg, 1);
    chk("R11 line low in msg", irq_level, 0);
    @(negedge clk);
    chk("R11 msg one cycle", irq_msg, 0);
    do_button;
    chk("R11 repeat no pulse", irq_msg, 0);
    wr(1'b1, 16'h0001, 2'b01);
    chk("R11 clear no pulse", irq_msg, 0);
    do_button;
    chk("R11 re-raise pulse", irq_msg, 1);
    msg_mode = 1'b0;
    @(negedge clk);
    chk("R11 legacy follows", irq_level, 1);

    // R12 detach
    wr(1'b0, 16'h07C0, 2'b11);
    chk("R12 detach pulse", detach, 1);
    rd(1'b1, v); chk("R12 pres clr pdc set", {v[6], v[3]}, 2'b01);
    chk("R12 link clr", link_up, 0);
    @(negedge clk);
    chk("R12 detach one cycle", detach, 0);
    do_attach;
    wr(1'b0, 16'h07C0, 2'b11);
    chk("R12 no repeat", detach, 0);
    chk("R12 still present", present, 1);
    wr(1'b0, 16'h03C0, 2'b11);
    wr(1'b0, 16'h06C0, 2'b11);
    chk("R12 blink no detach", detach, 0);
    wr(1'b0, 16'h07C0, 2'b11);
    chk("R12 edge detach", detach, 1);

    // R6/R8 interlock
    lock_present = 1'b1;
    wr(1'b0, 16'h0FC0, 2'b11);
    rd(1'b1, v); chk("R6 toggle on", v[7], 1);
    rd(1'b0, v); chk("R2 bit11 reads 0", v, 16'h07C0);
    do_attach;
    chk("R8 attach refused", present, 0);
    wr(1'b0, 16'h0FC0, 2'b11);
    rd(1'b1, v); chk("R6 toggle off", v[7], 0);
    do_attach;
    chk("R8 attach after unlock", present, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule